// File: doc/BRIEF.md
# Linear Burst Read Sequencer

This block sits on the memory side of a synchronous read interface. When chip select is high and the configuration selects synchronous mode, a pulse on the address strobe captures a start address. After a programmable initial latency, the block walks a linear burst of 2, 4 or 8 transfers. On each clock it fetches one word through a simple combinational read port and presents it on a registered output. The address wraps inside the burst-aligned block.

An active-low end-of-burst marker is registered together with the data. A configuration bit chooses whether it marks the last transfer or the one before it. Output enable only decides whether the data bus and the marker are driven, and it never stalls the burst. Chip select, a fresh strobe and reset are the only things that end a burst early. Pin release is modelled as drive-enable flags and not as tristate pins.

Top module: `lburst_seq`

## Requirements
- R1: Reset (synchronous, active high) sets the configuration to its default value 0x16: synchronous mode off, latency 3, length code 1, marker on the last transfer. With this default an address strobe starts nothing, and no data is driven.
- R2: Configuration bit fields are bit0 = synchronous enable, bits[3:1] = latency L (0 is treated as 1), bits[5:4] = length code, bit6 = early marker. An accepted strobe latches the address, and the first word becomes valid L clocks after the strobe edge.
- R3: The burst presents N consecutive words, one per clock, with N = 2, 4 or 8 for length codes 0, 1 and 2/3. Word k comes from address (A & ~(N-1)) | ((A+k) & (N-1)), where A is the start address.
- R4: With bit6 clear, eob_n_o is low for exactly one clock, aligned with the last word of the burst.
- R5: With bit6 set, eob_n_o is low for exactly one clock, aligned with the second-to-last word. For N=2 this is the first word.
- R6: While out_en_i is low, data_drive_o and eob_drive_o are low, but the burst keeps advancing. When out_en_i returns, the word scheduled for that cycle is shown.
- R7: chip_sel_i low releases both drive flags in the same cycle and ends the burst at the next edge. No further words appear after chip select returns.
- R8: An accepted strobe during a burst abandons it and starts a new burst from the new address with full latency.
- R9: Reset during a burst ends it at once and restores the default configuration.
- R10: A configuration write is taken only when no further word of a burst is pending. A write made earlier is dropped.
- R11: An address strobe while chip_sel_i is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_sel_i | input | 1 | Chip select, active high |
| out_en_i | input | 1 | Output enable, active high |
| addr_strobe_i | input | 1 | Address-valid strobe |
| start_addr_i | input | AW | Burst start address |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 7 | Configuration write value |
| mem_addr_o | output | AW | Read-port address |
| mem_rdata_i | input | DW | Read-port data, combinational from mem_addr_o |
| data_o | output | DW | Burst data word |
| data_drive_o | output | 1 | Data bus driven |
| eob_n_o | output | 1 | End-of-burst marker, active low |
| eob_drive_o | output | 1 | Marker driven |

## Verification
The bench aborts bursts with chip select and with reset at every cycle offset from the strobe edge through the final word. A design that let a stale word leak out after the abort is caught, and so is one that failed to clear the marker. Marker placement is checked for both bit6 settings, including N=2, where the early marker lands on the first word; an off-by-one index would shift or duplicate the low pulse. Output enable is dropped mid-burst to expose a design that stalls instead of advancing. Configuration writes land during a busy burst and must not alter the next burst's latency or length. Start addresses that are not aligned check the wrap.

// File: rtl/lburst_pkg.sv
package lburst_pkg;

    // Configuration register layout: {early, len_code, latency, sync_en}
    typedef struct packed {
        logic       early_eob;
        logic [1:0] len_code;
        logic [2:0] latency;
        logic       sync_en;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);
    localparam cfg_t CFG_DEFAULT = '{early_eob: 1'b0, len_code: 2'd1,
                                     latency: 3'd3, sync_en: 1'b0};

    typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_BURST} state_e;

    function automatic logic [3:0] burst_beats(input logic [1:0] code);
        case (code)
            2'd0:    return 4'd2;
            2'd1:    return 4'd4;
            default: return 4'd8;
        endcase
    endfunction

    function automatic logic [2:0] eff_latency(input logic [2:0] lat);
        return (lat == 3'd0) ? 3'd1 : lat;
    endfunction

endpackage

// File: rtl/lburst_cfg.sv
module lburst_cfg
    import lburst_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic [CFG_W-1:0] wdata_i,
    input  logic             busy_i,
    output cfg_t             cfg_o
);
    always_ff @(posedge clk) begin
        if (rst)
            cfg_o <= CFG_DEFAULT;
        else if (wr_i && !busy_i)
            cfg_o <= cfg_t'(wdata_i);
    end
endmodule

// File: rtl/lburst_ctrl.sv
module lburst_ctrl
    import lburst_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_i,
    input  logic       start_i,
    input  cfg_t       cfg_i,
    output logic       load_o,
    output logic       eob_hit_o,
    output logic [3:0] beats_o,
    output logic       busy_o
);
    state_e     state_q;
    logic [2:0] wait_q;
    logic [3:0] beat_q;
    logic [3:0] beats_q;
    logic       early_q;
    logic [3:0] mark_idx;

    assign beats_o  = beats_q;
    assign busy_o   = (state_q != ST_IDLE);
    assign load_o   = cs_i && !start_i &&
                      ((state_q == ST_WAIT && wait_q == 3'd0) || state_q == ST_BURST);
    assign mark_idx = beats_q - 4'd1 - {3'd0, early_q};
    assign eob_hit_o = load_o && (beat_q == mark_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            wait_q  <= '0;
            beat_q  <= '0;
            beats_q <= 4'd2;
            early_q <= 1'b0;
        end else if (!cs_i) begin
            state_q <= ST_IDLE;
        end else if (start_i) begin
            state_q <= ST_WAIT;
            wait_q  <= eff_latency(cfg_i.latency) - 3'd1;
            beat_q  <= '0;
            beats_q <= burst_beats(cfg_i.len_code);
            early_q <= cfg_i.early_eob;
        end else begin
            case (state_q)
                ST_WAIT: begin
                    if (wait_q == 3'd0) begin
                        beat_q  <= 4'd1;
                        state_q <= ST_BURST;
                    end else begin
                        wait_q <= wait_q - 3'd1;
                    end
                end
                ST_BURST: begin
                    beat_q <= beat_q + 4'd1;
                    if (beat_q == beats_q - 4'd1)
                        state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lburst_addr.sv
module lburst_addr #(
    parameter int AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [AW-1:0] start_addr_i,
    input  logic          load_i,
    input  logic [3:0]    beats_i,
    output logic [AW-1:0] addr_o
);
    logic [AW-1:0] mask;
    logic [AW-1:0] nxt;

    assign mask = {{(AW-4){1'b0}}, beats_i - 4'd1};
    assign nxt  = (addr_o & ~mask) | ((addr_o + AW'(1)) & mask);

    always_ff @(posedge clk) begin
        if (rst)
            addr_o <= '0;
        else if (start_i)
            addr_o <= start_addr_i;
        else if (load_i)
            addr_o <= nxt;
    end
endmodule

// File: rtl/lburst_out.sv
module lburst_out #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_i,
    input  logic          start_i,
    input  logic          load_i,
    input  logic          eob_hit_i,
    input  logic [DW-1:0] rdata_i,
    output logic          valid_o,
    output logic          eob_o,
    output logic [DW-1:0] data_o
);
    always_ff @(posedge clk) begin
        if (rst || !cs_i || start_i) begin
            valid_o <= 1'b0;
            eob_o   <= 1'b0;
            if (rst) data_o <= '0;
        end else begin
            valid_o <= load_i;
            eob_o   <= load_i && eob_hit_i;
            if (load_i) data_o <= rdata_i;
        end
    end
endmodule

// File: rtl/lburst_seq.sv
module lburst_seq
    import lburst_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             chip_sel_i,
    input  logic             out_en_i,
    input  logic             addr_strobe_i,
    input  logic [AW-1:0]    start_addr_i,
    input  logic             cfg_wr_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    output logic [AW-1:0]    mem_addr_o,
    input  logic [DW-1:0]    mem_rdata_i,
    output logic [DW-1:0]    data_o,
    output logic             data_drive_o,
    output logic             eob_n_o,
    output logic             eob_drive_o
);
    cfg_t       cfg_q;
    logic       busy;
    logic       strobe_ok;
    logic       load;
    logic       eob_hit;
    logic [3:0] beats;
    logic       valid_q;
    logic       eob_q;

    assign strobe_ok = addr_strobe_i && chip_sel_i && cfg_q.sync_en;

    lburst_cfg u_cfg (
        .clk(clk), .rst(rst), .wr_i(cfg_wr_i), .wdata_i(cfg_wdata_i),
        .busy_i(busy), .cfg_o(cfg_q)
    );

    lburst_ctrl u_ctrl (
        .clk(clk), .rst(rst), .cs_i(chip_sel_i), .start_i(strobe_ok),
        .cfg_i(cfg_q), .load_o(load), .eob_hit_o(eob_hit),
        .beats_o(beats), .busy_o(busy)
    );

    lburst_addr #(.AW(AW)) u_addr (
        .clk(clk), .rst(rst), .start_i(strobe_ok), .start_addr_i(start_addr_i),
        .load_i(load), .beats_i(beats), .addr_o(mem_addr_o)
    );

    lburst_out #(.DW(DW)) u_out (
        .clk(clk), .rst(rst), .cs_i(chip_sel_i), .start_i(strobe_ok),
        .load_i(load), .eob_hit_i(eob_hit), .rdata_i(mem_rdata_i),
        .valid_o(valid_q), .eob_o(eob_q), .data_o(data_o)
    );

    assign data_drive_o = valid_q && out_en_i && chip_sel_i;
    assign eob_drive_o  = out_en_i && chip_sel_i;
    assign eob_n_o      = ~eob_q;
endmodule

// File: rtl/lburst_seq_chk.sv
module lburst_seq_chk
    import lburst_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic chip_sel_i,
    input logic addr_strobe_i,
    input logic cfg_wr_i,
    input logic data_drive_o,
    input logic eob_n_o,
    input logic busy,
    input logic strobe_ok,
    input cfg_t cfg_q
);
    // R4 / R5: the marker is low for a single cycle only
    a_r4_eob_single: assert property (@(posedge clk) disable iff (rst)
        !eob_n_o |=> eob_n_o);

    // R7: after chip select drops, nothing is driven in the following cycle
    a_r7_cs_abort: assert property (@(posedge clk) disable iff (rst)
        !chip_sel_i |=> (!data_drive_o && eob_n_o));

    // R11: a strobe without chip select leaves the block idle
    a_r11_strobe_no_cs: assert property (@(posedge clk) disable iff (rst)
        (addr_strobe_i && !chip_sel_i) |=> !busy);

    // R10: configuration writes during a pending burst are dropped
    a_r10_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr_i && busy) |=> $stable(cfg_q));

    // R2 / R8: an accepted strobe never shows data in the next cycle
    a_r2_latency_min: assert property (@(posedge clk) disable iff (rst)
        strobe_ok |=> (busy && !data_drive_o));

    // R9 / R1: leaving reset, the block is idle with default configuration
    a_r9_reset_idle: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && eob_n_o && cfg_q == CFG_DEFAULT));
endmodule

bind lburst_seq lburst_seq_chk u_chk (
    .clk(clk), .rst(rst), .chip_sel_i(chip_sel_i), .addr_strobe_i(addr_strobe_i),
    .cfg_wr_i(cfg_wr_i), .data_drive_o(data_drive_o), .eob_n_o(eob_n_o),
    .busy(busy), .strobe_ok(strobe_ok), .cfg_q(cfg_q)
);

// File: tb/tb_lburst_seq.sv
module tb_lburst_seq;
    localparam int AW = 12;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cs = 1'b0, oe = 1'b0, strobe = 1'b0, cfg_wr = 1'b0;
    logic [AW-1:0] saddr = '0;
    logic [6:0]    wdata = '0;
    logic [AW-1:0] maddr;
    logic [DW-1:0] rdata, dout;
    logic          ddrv, eobn, edrv;

    always #10 clk = ~clk;   // 50 MHz

    function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
        return {4'hC, a, 4'h3, ~a};
    endfunction
    assign rdata = memf(maddr);

    lburst_seq #(.AW(AW), .DW(DW)) dut (
        .clk(clk), .rst(rst), .chip_sel_i(cs), .out_en_i(oe),
        .addr_strobe_i(strobe), .start_addr_i(saddr), .cfg_wr_i(cfg_wr),
        .cfg_wdata_i(wdata), .mem_addr_o(maddr), .mem_rdata_i(rdata),
        .data_o(dout), .data_drive_o(ddrv), .eob_n_o(eobn), .eob_drive_o(edrv)
    );

    int    errors = 0, checks = 0;
    string cur_req = "R1";
    bit    done = 0;

    // ---------------- behavioural reference model ----------------
    typedef struct { bit v; bit e; logic [DW-1:0] d; } ent_t;
    ent_t       q[$];
    logic [6:0] m_cfg = 7'h16;

    task automatic build(input logic [AW-1:0] a);
        int   lat, n, mark;
        ent_t x;
        lat  = (m_cfg[3:1] == 0) ? 1 : int'(m_cfg[3:1]);
        n    = (m_cfg[5:4] == 0) ? 2 : (m_cfg[5:4] == 1) ? 4 : 8;
        mark = m_cfg[6] ? n - 2 : n - 1;
        q.delete();
        for (int i = 0; i < lat; i++) begin
            x.v = 0; x.e = 0; x.d = '0; q.push_back(x);
        end
        for (int k = 0; k < n; k++) begin
            logic [AW-1:0] ad;
            ad  = (a & ~AW'(n - 1)) | ((a + AW'(k)) & AW'(n - 1));
            x.v = 1; x.e = (k == mark); x.d = memf(ad);
            q.push_back(x);
        end
    endtask

    always @(posedge clk) begin
        bit         busy_m;
        logic [6:0] ncfg;
        busy_m = q.size() > 1;
        if (rst) begin
            q.delete();
            m_cfg = 7'h16;
        end else begin
            ncfg = (cfg_wr && !busy_m) ? wdata : m_cfg;
            if (!cs) q.delete();
            else if (strobe && m_cfg[0]) build(saddr);
            else if (q.size() > 0) void'(q.pop_front());
            m_cfg = ncfg;
        end
    end

    // ---------------- per-cycle comparison ----------------
    task automatic chk(input bit ok, input string what, input logic [DW-1:0] got,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h at %0t", cur_req, what, got, exp, $time);
        end
    endtask

    always begin
        ent_t f;
        @(posedge clk);
        #15;
        if (!rst && !done) begin
            if (q.size() > 0) f = q[0];
            else begin f.v = 0; f.e = 0; f.d = '0; end
            chk(ddrv == (f.v && oe && cs), "data_drive", DW'(ddrv), DW'(f.v && oe && cs));
            chk(edrv == (oe && cs), "eob_drive", DW'(edrv), DW'(oe && cs));
            chk(eobn == !(f.v && f.e), "eob_n", DW'(eobn), DW'(!(f.v && f.e)));
            if (f.v) chk(dout == f.d, "data", dout, f.d);
        end
    end

    // ---------------- stimulus ----------------
    task automatic cyc(input int n = 1);
        repeat (n) begin @(posedge clk); #5; end
    endtask
    task automatic wcfg(input logic [6:0] v);
        cfg_wr = 1; wdata = v; cyc(); cfg_wr = 0;
    endtask
    task automatic go(input logic [AW-1:0] a);
        strobe = 1; saddr = a; cyc(); strobe = 0;
    endtask
    task automatic do_reset();
        rst = 1; cyc(2); rst = 0;
    endtask

    initial begin
        cyc(3); rst = 0; cs = 1; oe = 1;
        // R1: default config is asynchronous; strobe starts nothing
        cur_req = "R1"; go(12'h020); cyc(10);
        // R2 R3 R4: L=3, N=4, marker on last, wrapping start
        cur_req = "R2"; wcfg(7'h17); go(12'h012); cyc(10);
        cur_req = "R3"; wcfg(7'h05); go(12'h007); cyc(8);
        wcfg(7'h23); go(12'h02D); cyc(12);
        wcfg(7'h31); go(12'h003); cyc(12);
        cur_req = "R4"; wcfg(7'h17); go(12'h104); cyc(10);
        // R5: early marker, N=8 and N=2
        cur_req = "R5"; wcfg(7'h63); go(12'h045); cyc(12);
        wcfg(7'h49); go(12'h001); cyc(8);
        // R6: output enable dropped mid-burst
        cur_req = "R6"; wcfg(7'h17); go(12'h0A1); cyc(3); oe = 0; cyc(3); oe = 1; cyc(6);
        // R7: chip select abort at every offset
        cur_req = "R7";
        for (int off = 0; off < 9; off++) begin
            go(12'h200 + 12'(off)); cyc(off); cs = 0; cyc(); cs = 1; cyc(8);
        end
        // R8: restart during burst
        cur_req = "R8"; go(12'h300); cyc(4); go(12'h3F6); cyc(10);
        // R9: reset abort at every offset, default restored
        cur_req = "R9";
        for (int off = 0; off < 9; off++) begin
            wcfg(7'h17); go(12'h400 + 12'(off)); cyc(off); do_reset(); go(12'h410); cyc(6);
        end
        // R10: write while busy dropped
        cur_req = "R10"; wcfg(7'h17); go(12'h500); cyc(2); wcfg(7'h23); cyc(8);
        go(12'h509); cyc(10);
        // R11: strobe with chip select low
        cur_req = "R11"; cs = 0; go(12'h600); cs = 1; cyc(10);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule